// File: doc/BRIEF.md
# Cache Request Port Limiter

This block arbitrates the request slots a load/store queue may use toward a data cache in one clock cycle. Read slots and write slots are budgeted separately, each with its own parameterised limit, and both budgets start fresh every cycle. Load lanes, store-writeback lanes and the second halves of split (unaligned) accesses compete for these slots. Each lane offers a request with a valid bit and gets a same-cycle ready. The ready is combinational from the valids of this cycle and from the block's registered state.

Back-pressure works this way. A request whose ready is low is not taken. A load lane refused this way has its delayed flag set, and the issue logic retries it later. A store lane keeps presenting its request in a later cycle. A split access whose first half is accepted is always completed by the block. Its second half goes out in the same cycle (`*_hi_go`) if a slot is left. If no slot is left, the block holds the second half and sends it at the head of the next cycle. The block also counts every refused request, separately for reads and writes.

Top module: `cache_port_limiter`

## Requirements
- R1: In any cycle the read grants (held split-load half, load first halves, load second halves) number at most RD_LIMIT, and the write grants number at most WR_LIMIT. Both limits default to 1, and the budgets refill every cycle.
- R2: Read slots go first to a held split-load half and then to load lanes in ascending lane order. A valid load lane gets `ld_ready`=1 only if a read slot remains; once one valid lane is refused, every higher lane is refused in that cycle too.
- R3: If a split load's first half is accepted and no read slot remains, its second half is held. In the next cycle `split_pend`=1 and `split_pend_tid` shows the owning lane's thread. In that same cycle `split_go`=1 with `split_go_tid` equal to that thread, and it uses a read slot ahead of all loads. The held half is then gone.
- R4: One cycle after a valid load lane is refused, `lq_delayed[idx]` is 1 for that lane's queue index. One cycle after a load is accepted, its bit is 0.
- R5: A forwarding clear (`fwd_clr_valid`, `fwd_clr_idx`) or a reschedule clear (`rsch_clr_valid`, `rsch_clr_idx`) makes that bit 0 in the next cycle. It wins over a refusal of the same index in the same cycle.
- R6: Write slots go first to a held store half, then to store lanes in ascending order. Once a valid store lane is refused, all higher lanes are refused for the cycle.
- R7: A split store whose first half is accepted sends its second half in the same cycle (`st_hi_go`) if a write slot remains. Otherwise the half is held, `st_pend`=1 in the next cycle and `st_pend_go`=1 in that cycle, ahead of all store lanes.
- R8: `rd_block_cnt` grows, one cycle later, by the number of refused valid load lanes plus one for each split-load half that is held.
- R9: `wr_block_cnt` grows, one cycle later, by the number of refused valid store lanes plus one for each held split-store half.
- R10: While `flush_valid`=1 with a `flush_tid` equal to the held split-load half's thread, that half is discarded (`split_go`=0) and `split_pend` is 0 in the next cycle. A flush of another thread leaves it issuing.
- R11: After reset both counters are zero, all delayed flags are zero, and no half is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | LD_LANES | Load lane presents a request |
| ld_split | input | LD_LANES | Load lane request is split in two halves |
| ld_tid | input | LD_LANES*TID_W | Thread of each load lane |
| ld_idx | input | LD_LANES*IDX_W | Load queue index of each lane |
| ld_ready | output | LD_LANES | First half accepted this cycle |
| ld_hi_go | output | LD_LANES | Second half sent this cycle |
| st_valid | input | ST_LANES | Store lane presents a writeback |
| st_split | input | ST_LANES | Store lane writeback is split |
| st_ready | output | ST_LANES | Store first half accepted this cycle |
| st_hi_go | output | ST_LANES | Store second half sent this cycle |
| split_pend | output | 1 | A split-load half is held |
| split_pend_tid | output | TID_W | Thread of the held load half |
| split_go | output | 1 | Held load half issues this cycle |
| split_go_tid | output | TID_W | Thread of the issuing held half |
| st_pend | output | 1 | A split-store half is held |
| st_pend_go | output | 1 | Held store half issues this cycle |
| fwd_clr_valid | input | 1 | Load satisfied by forwarding |
| fwd_clr_idx | input | IDX_W | Its load queue index |
| rsch_clr_valid | input | 1 | Load rescheduled |
| rsch_clr_idx | input | IDX_W | Its load queue index |
| flush_valid | input | 1 | Pipeline flush of a thread |
| flush_tid | input | TID_W | Flushed thread |
| lq_delayed | output | LQ_DEPTH | Delayed flag per load queue entry |
| rd_block_cnt | output | CNT_W | Refused read requests, running total |
| wr_block_cnt | output | CNT_W | Refused write requests, running total |

## Verification
A wrong slot count shows up in the same cycle as a ready, a second-half go or a held-half issue where none belongs. A budget that fails to refill shows up as readies missing in the following cycle. A lost or stale held half shows up exactly one cycle after parking, as `split_go` or `st_pend_go` being wrong, or as the wrong thread id. A bad delayed flag or a bad counter step becomes visible at the ports one edge after the event that caused it.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
  typedef logic [7:0] slot_t;
  localparam slot_t SLOT_ONE = 8'd1;
endpackage

// File: rtl/cpl_read_arb.sv
module cpl_read_arb
  import cpl_pkg::*;
#(
  parameter int LANES = 2,
  parameter int LIMIT = 1,
  parameter int TID_W = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       ld_valid,
  input  logic [LANES-1:0]       ld_split,
  input  logic [LANES*TID_W-1:0] ld_tid,
  input  logic                   flush_valid,
  input  logic [TID_W-1:0]       flush_tid,
  output logic [LANES-1:0]       ld_ready,
  output logic [LANES-1:0]       ld_hi_go,
  output logic                   pend_valid,
  output logic [TID_W-1:0]       pend_tid,
  output logic                   pend_go,
  output logic [TID_W-1:0]       pend_go_tid,
  output slot_t                  blocked
);
  localparam slot_t LIM = slot_t'(LIMIT);

  logic             pend_q;
  logic [TID_W-1:0] pend_tid_q;
  logic             park;
  logic [TID_W-1:0] park_tid;
  slot_t            used;

  always_comb begin
    used     = '0;
    blocked  = '0;
    park     = 1'b0;
    park_tid = '0;
    ld_ready = '0;
    ld_hi_go = '0;
    pend_go  = pend_q && !(flush_valid && flush_tid == pend_tid_q);
    if (pend_go) used = SLOT_ONE;
    for (int i = 0; i < LANES; i++) begin
      if (ld_valid[i]) begin
        if (used < LIM) begin
          ld_ready[i] = 1'b1;
          used = used + SLOT_ONE;
          if (ld_split[i]) begin
            if (used < LIM) begin
              ld_hi_go[i] = 1'b1;
              used = used + SLOT_ONE;
            end else begin
              blocked = blocked + SLOT_ONE;
              if (!(flush_valid && flush_tid == ld_tid[i*TID_W +: TID_W])) begin
                park     = 1'b1;
                park_tid = ld_tid[i*TID_W +: TID_W];
              end
            end
          end
        end else begin
          blocked = blocked + SLOT_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_tid_q <= '0;
    end else begin
      pend_q     <= park;
      pend_tid_q <= park_tid;
    end
  end

  assign pend_valid  = pend_q;
  assign pend_tid    = pend_tid_q;
  assign pend_go_tid = pend_tid_q;

  a_r1_read_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pend_go, ld_ready, ld_hi_go}) <= LIMIT);

  a_r3_park_then_go: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> (pend_go || (flush_valid && flush_tid == $past(park_tid))));

  generate
    for (genvar g = 1; g < LANES; g++) begin : g_ord
      a_r2_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid[g-1] && !ld_ready[g-1]) |-> !ld_ready[g]);
    end
  endgenerate
endmodule

// File: rtl/cpl_write_arb.sv
module cpl_write_arb
  import cpl_pkg::*;
#(
  parameter int LANES = 2,
  parameter int LIMIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] st_valid,
  input  logic [LANES-1:0] st_split,
  output logic [LANES-1:0] st_ready,
  output logic [LANES-1:0] st_hi_go,
  output logic             pend_valid,
  output logic             pend_go,
  output slot_t            blocked
);
  localparam slot_t LIM = slot_t'(LIMIT);

  logic  pend_q;
  logic  park;
  slot_t used;

  always_comb begin
    used     = '0;
    blocked  = '0;
    park     = 1'b0;
    st_ready = '0;
    st_hi_go = '0;
    pend_go  = pend_q;
    if (pend_go) used = SLOT_ONE;
    for (int i = 0; i < LANES; i++) begin
      if (st_valid[i]) begin
        if (used < LIM) begin
          st_ready[i] = 1'b1;
          used = used + SLOT_ONE;
          if (st_split[i]) begin
            if (used < LIM) begin
              st_hi_go[i] = 1'b1;
              used = used + SLOT_ONE;
            end else begin
              blocked = blocked + SLOT_ONE;
              park    = 1'b1;
            end
          end
        end else begin
          blocked = blocked + SLOT_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= park;
  end

  assign pend_valid = pend_q;

  a_r1_write_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pend_go, st_ready, st_hi_go}) <= LIMIT);

  a_r7_store_park_go: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> pend_go);

  generate
    for (genvar g = 1; g < LANES; g++) begin : g_stop
      a_r6_store_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid[g-1] && !st_ready[g-1]) |-> !st_ready[g]);
    end
  endgenerate
endmodule

// File: rtl/cpl_delay_flags.sv
module cpl_delay_flags #(
  parameter int LANES = 2,
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       ld_valid,
  input  logic [LANES-1:0]       ld_ready,
  input  logic [LANES*IDX_W-1:0] ld_idx,
  input  logic                   fwd_v,
  input  logic [IDX_W-1:0]       fwd_idx,
  input  logic                   rs_v,
  input  logic [IDX_W-1:0]       rs_idx,
  output logic [DEPTH-1:0]       delayed
);
  logic [DEPTH-1:0] flags_q;
  logic [DEPTH-1:0] flags_d;

  always_comb begin
    flags_d = flags_q;
    for (int i = 0; i < LANES; i++) begin
      if (ld_valid[i]) flags_d[ld_idx[i*IDX_W +: IDX_W]] = !ld_ready[i];
    end
    if (fwd_v) flags_d[fwd_idx] = 1'b0;
    if (rs_v)  flags_d[rs_idx]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign delayed = flags_q;

  a_r5_fwd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_v |=> !delayed[$past(fwd_idx)]);

  a_r5_rsch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rs_v |=> !delayed[$past(rs_idx)]);
endmodule

// File: rtl/cache_port_limiter.sv
module cache_port_limiter
  import cpl_pkg::*;
#(
  parameter int RD_LIMIT = 1,
  parameter int WR_LIMIT = 1,
  parameter int LD_LANES = 2,
  parameter int ST_LANES = 2,
  parameter int LQ_DEPTH = 8,
  parameter int TID_W    = 1,
  parameter int CNT_W    = 16,
  parameter int IDX_W    = $clog2(LQ_DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LD_LANES-1:0]       ld_valid,
  input  logic [LD_LANES-1:0]       ld_split,
  input  logic [LD_LANES*TID_W-1:0] ld_tid,
  input  logic [LD_LANES*IDX_W-1:0] ld_idx,
  output logic [LD_LANES-1:0]       ld_ready,
  output logic [LD_LANES-1:0]       ld_hi_go,
  input  logic [ST_LANES-1:0]       st_valid,
  input  logic [ST_LANES-1:0]       st_split,
  output logic [ST_LANES-1:0]       st_ready,
  output logic [ST_LANES-1:0]       st_hi_go,
  output logic                      split_pend,
  output logic [TID_W-1:0]          split_pend_tid,
  output logic                      split_go,
  output logic [TID_W-1:0]          split_go_tid,
  output logic                      st_pend,
  output logic                      st_pend_go,
  input  logic                      fwd_clr_valid,
  input  logic [IDX_W-1:0]          fwd_clr_idx,
  input  logic                      rsch_clr_valid,
  input  logic [IDX_W-1:0]          rsch_clr_idx,
  input  logic                      flush_valid,
  input  logic [TID_W-1:0]          flush_tid,
  output logic [LQ_DEPTH-1:0]       lq_delayed,
  output logic [CNT_W-1:0]          rd_block_cnt,
  output logic [CNT_W-1:0]          wr_block_cnt
);
  slot_t rd_blocked;
  slot_t wr_blocked;
  logic [CNT_W-1:0] rd_cnt_q;
  logic [CNT_W-1:0] wr_cnt_q;

  cpl_read_arb #(.LANES(LD_LANES), .LIMIT(RD_LIMIT), .TID_W(TID_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_split(ld_split), .ld_tid(ld_tid),
    .flush_valid(flush_valid), .flush_tid(flush_tid),
    .ld_ready(ld_ready), .ld_hi_go(ld_hi_go),
    .pend_valid(split_pend), .pend_tid(split_pend_tid),
    .pend_go(split_go), .pend_go_tid(split_go_tid),
    .blocked(rd_blocked)
  );

  cpl_write_arb #(.LANES(ST_LANES), .LIMIT(WR_LIMIT)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_split(st_split),
    .st_ready(st_ready), .st_hi_go(st_hi_go),
    .pend_valid(st_pend), .pend_go(st_pend_go),
    .blocked(wr_blocked)
  );

  cpl_delay_flags #(.LANES(LD_LANES), .DEPTH(LQ_DEPTH), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_idx(ld_idx),
    .fwd_v(fwd_clr_valid), .fwd_idx(fwd_clr_idx),
    .rs_v(rsch_clr_valid), .rs_idx(rsch_clr_idx),
    .delayed(lq_delayed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt_q <= '0;
      wr_cnt_q <= '0;
    end else begin
      rd_cnt_q <= rd_cnt_q + CNT_W'(rd_blocked);
      wr_cnt_q <= wr_cnt_q + CNT_W'(wr_blocked);
    end
  end

  assign rd_block_cnt = rd_cnt_q;
  assign wr_block_cnt = wr_cnt_q;

  a_r8_rd_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid == '0) |=> (rd_block_cnt == $past(rd_block_cnt)));

  a_r9_wr_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid == '0) |=> (wr_block_cnt == $past(wr_block_cnt)));
endmodule

// File: tb/cache_port_limiter_tb.sv
module cache_port_limiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ld_valid, ld_split, ld_ready, ld_hi_go;
  logic [1:0] st_valid, st_split, st_ready, st_hi_go;
  logic [1:0] ld_tid;
  logic [5:0] ld_idx;
  logic split_pend, split_go, st_pend, st_pend_go;
  logic [0:0] split_pend_tid, split_go_tid, flush_tid;
  logic fwd_clr_valid, rsch_clr_valid, flush_valid;
  logic [2:0] fwd_clr_idx, rsch_clr_idx;
  logic [7:0] lq_delayed;
  logic [15:0] rd_block_cnt, wr_block_cnt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_port_limiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_split(ld_split), .ld_tid(ld_tid), .ld_idx(ld_idx),
    .ld_ready(ld_ready), .ld_hi_go(ld_hi_go),
    .st_valid(st_valid), .st_split(st_split),
    .st_ready(st_ready), .st_hi_go(st_hi_go),
    .split_pend(split_pend), .split_pend_tid(split_pend_tid),
    .split_go(split_go), .split_go_tid(split_go_tid),
    .st_pend(st_pend), .st_pend_go(st_pend_go),
    .fwd_clr_valid(fwd_clr_valid), .fwd_clr_idx(fwd_clr_idx),
    .rsch_clr_valid(rsch_clr_valid), .rsch_clr_idx(rsch_clr_idx),
    .flush_valid(flush_valid), .flush_tid(flush_tid),
    .lq_delayed(lq_delayed), .rd_block_cnt(rd_block_cnt), .wr_block_cnt(wr_block_cnt)
  );

  // {ld_valid, ld_split, st_valid, st_split, exp ld_ready, ld_hi_go, st_ready, st_hi_go, split_go, st_pend_go}
  localparam logic [17:0] VEC [NVEC] = '{
    18'b01_00_01_00_01_00_01_00_0_0,
    18'b11_00_11_00_01_00_01_00_0_0,
    18'b01_01_01_01_01_00_01_00_0_0,
    18'b11_00_01_00_00_00_00_00_1_1,
    18'b10_00_00_00_10_00_00_00_0_0,
    18'b00_00_00_00_00_00_00_00_0_0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ld_valid = '0; ld_split = '0; st_valid = '0; st_split = '0;
    fwd_clr_valid = 1'b0; fwd_clr_idx = '0;
    rsch_clr_valid = 1'b0; rsch_clr_idx = '0;
    flush_valid = 1'b0; flush_tid = '0;
  endtask

  initial begin
    ld_tid = 2'b10;                // lane0 thread 0, lane1 thread 1
    ld_idx = {3'd5, 3'd2};         // lane0 index 2, lane1 index 5
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 rd_cnt", 32'(rd_block_cnt), 0);
    chk("R11 wr_cnt", 32'(wr_block_cnt), 0);
    chk("R11 delayed", 32'(lq_delayed), 0);
    chk("R11 pend", {30'b0, split_pend, st_pend}, 0);

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      idle();
      {ld_valid, ld_split, st_valid, st_split} = VEC[v][17:10];
      #1;
      chk("R2 ld_ready", 32'(ld_ready), 32'(VEC[v][9:8]));
      chk("R3 ld_hi_go", 32'(ld_hi_go), 32'(VEC[v][7:6]));
      chk("R6 st_ready", 32'(st_ready), 32'(VEC[v][5:4]));
      chk("R7 st_hi_go", 32'(st_hi_go), 32'(VEC[v][3:2]));
      chk("R3 split_go", 32'(split_go), 32'(VEC[v][1]));
      chk("R7 st_pend_go", 32'(st_pend_go), 32'(VEC[v][0]));
      if (v == 3) begin
        chk("R3 split_pend", 32'(split_pend), 1);
        chk("R3 split_go_tid", 32'(split_go_tid), 0);
        chk("R7 st_pend", 32'(st_pend), 1);
      end
    end
    @(negedge clk);
    idle();
    #1;
    chk("R8 rd_cnt", 32'(rd_block_cnt), 4);
    chk("R9 wr_cnt", 32'(wr_block_cnt), 3);
    chk("R4 delayed", 32'(lq_delayed), 32'h04);
    chk("R1 budget refilled", 32'(split_pend), 0);

    fwd_clr_valid = 1'b1; fwd_clr_idx = 3'd2;
    @(negedge clk); idle(); #1;
    chk("R5 fwd clear", 32'(lq_delayed), 0);

    ld_valid = 2'b11; fwd_clr_valid = 1'b1; fwd_clr_idx = 3'd5;
    @(negedge clk); idle(); #1;
    chk("R5 clear beats deny", 32'(lq_delayed), 0);
    chk("R8 rd_cnt deny", 32'(rd_block_cnt), 5);

    ld_valid = 2'b11;
    @(negedge clk); idle(); #1;
    chk("R4 deny sets", 32'(lq_delayed), 32'h20);
    rsch_clr_valid = 1'b1; rsch_clr_idx = 3'd5;
    @(negedge clk); idle(); #1;
    chk("R5 rsch clear", 32'(lq_delayed), 0);

    ld_valid = 2'b10; ld_split = 2'b10;
    #1;
    chk("R2 lane1 alone", 32'(ld_ready), 2);
    @(negedge clk); idle();
    flush_valid = 1'b1; flush_tid = 1'b0;
    #1;
    chk("R3 pend tid", 32'(split_pend_tid), 1);
    chk("R10 other flush keeps", 32'(split_go), 1);
    chk("R3 go tid", 32'(split_go_tid), 1);
    @(negedge clk); idle(); #1;
    chk("R8 rd_cnt park", 32'(rd_block_cnt), 7);

    ld_valid = 2'b01; ld_split = 2'b01;
    @(negedge clk); idle();
    flush_valid = 1'b1; flush_tid = 1'b0;
    #1;
    chk("R10 flush kills", 32'(split_go), 0);
    @(negedge clk); idle(); #1;
    chk("R10 pend cleared", 32'(split_pend), 0);
    chk("R8 rd_cnt final", 32'(rd_block_cnt), 8);
    chk("R9 wr_cnt final", 32'(wr_block_cnt), 3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule